// File: doc/BRIEF.md
# Burst Address and Write Control Front End

This block is the synchronous command and address stage in front of a burst SRAM array. On every rising clock edge it samples the external address, the chip enable, two burst-start strobes, the burst-advance input, the burst-order select and the write controls. From these it produces, one cycle later, the array address for the current beat and a per-lane write-enable vector.

A burst begins when either strobe loads the external address, which becomes the first beat. After that, the two low address bits come from an internal 2-bit beat counter. The counter moves forward only on cycles where the advance input is high and no strobe is acting. The order select picks linear order (start plus beat, modulo 4) or interleaved order (start XOR beat). The upper address bits never change inside a burst. Bursting is optional, because a fresh address can be loaded on every cycle.

Write enables come from a byte-write enable gated by per-lane selects. A global write overrides them and writes every lane. The data width is a parameter: 18 bits gives two 9-bit lanes and 36 bits gives four.

Top module: `burst_addr_front`

## Requirements
- R1: While reset is high, and on the first cycle after it, `beat_valid_o`, `lane_wr_o` and `desel_o` are all zero.
- R2: When `start_b_i` and `chip_en_i` are both high, the next cycle shows `beat_valid_o`=1 and `beat_addr_o` equal to the sampled `addr_i`, whatever the value of `start_a_i`.
- R3: When `start_a_i` and `chip_en_i` are high and `start_b_i` is low, the address is loaded in the same way as in R2.
- R4: When `start_a_i` is high, `chip_en_i` is low and `start_b_i` is low, the strobe is ignored. The burst continues as if no strobe were present.
- R5: When `start_b_i` is high and `chip_en_i` is low, the cycle is a deselect. The next cycle shows `desel_o`=1, `beat_valid_o`=0 and `lane_wr_o`=0, and the burst ends.
- R6: When no strobe acts during an active burst, the beat count rises by one (mod 4) if `adv_i`=1. If `adv_i`=0 the beat count is held, and so is the address.
- R7: With `interleave_i`=0, the low two address bits are (start + beat) mod 4. Bits above bit 1 stay at the loaded value for the whole burst, and a wrap never carries into them.
- R8: With `interleave_i`=1, the low two address bits are start XOR beat.
- R9: A load on every consecutive cycle presents each loaded address on the following cycle, with no lost cycles.
- R10: On a valid beat with `global_wr_i`=0 and `byte_wr_en_i`=1, `lane_wr_o` equals `byte_sel_i`. Bit i belongs to 9-bit lane i.
- R11: On a valid beat with `global_wr_i`=1, every bit of `lane_wr_o` is 1, regardless of `byte_wr_en_i` and `byte_sel_i`.
- R12: On a valid beat with both `global_wr_i` and `byte_wr_en_i` low, and on every cycle without a valid beat, `lane_wr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| chip_en_i | input | 1 | Chip enable, active high |
| start_a_i | input | 1 | Burst-start strobe gated by chip enable |
| start_b_i | input | 1 | Burst-start strobe, loads or deselects |
| adv_i | input | 1 | Burst advance |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| byte_wr_en_i | input | 1 | Byte-write enable |
| byte_sel_i | input | LANES | Per-lane byte select |
| global_wr_i | input | 1 | Write all lanes |
| beat_valid_o | output | 1 | A burst beat is active |
| beat_addr_o | output | ADDR_W | Array address of the beat |
| lane_wr_o | output | LANES | Per-lane write enables |
| desel_o | output | 1 | Previous cycle was a deselect |

## Verification
Several properties are checked on every clock cycle:
- a load appears unchanged one cycle later;
- a held beat keeps its address;
- the upper bits stay constant inside a burst;
- a deselect drives the write lanes to zero;
- a global write sets every lane;
- an idle cycle never writes.

Other behaviours appear only in the bench scenarios, because they need the reference model's history. These are the exact linear and interleaved sequences, including the wrap, the priority between the two strobes, the ignored gated strobe, and the byte-select pass-through.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_ADV   = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

    typedef struct packed {
        logic       live;
        logic [1:0] start;
        logic [1:0] beat;
    } burst_state_t;

    localparam int LANE_BITS = 9;
    localparam int BEAT_BITS = 2;

    function automatic logic [1:0] order_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ beat;
        else            r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/bsf_cmd_decode.sv
module bsf_cmd_decode
    import bsf_pkg::*;
(
    input  logic chip_en,
    input  logic start_a,
    input  logic start_b,
    input  logic adv,
    output cmd_e cmd
);
    always_comb begin
        if (start_b) begin
            cmd = chip_en ? CMD_LOAD : CMD_DESEL;
        end else if (start_a && chip_en) begin
            cmd = CMD_LOAD;
        end else begin
            cmd = adv ? CMD_ADV : CMD_HOLD;
        end
    end
endmodule

// File: rtl/bsf_burst_counter.sv
module bsf_burst_counter
    import bsf_pkg::*;
#(
    parameter int ADDR_W = 22,
    localparam int UP_W = ADDR_W - BEAT_BITS
)(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    output burst_state_t      st_next,
    output logic [UP_W-1:0]   upper_next
);
    burst_state_t    st_q;
    logic [UP_W-1:0] upper_q;

    always_comb begin
        st_next    = st_q;
        upper_next = upper_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_next.live  = 1'b1;
                st_next.start = addr[BEAT_BITS-1:0];
                st_next.beat  = '0;
                upper_next    = addr[ADDR_W-1:BEAT_BITS];
            end
            CMD_DESEL: st_next.live = 1'b0;
            CMD_ADV: begin
                if (st_q.live) st_next.beat = st_q.beat + 2'd1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            upper_q <= '0;
        end else begin
            st_q    <= st_next;
            upper_q <= upper_next;
        end
    end
endmodule

// File: rtl/bsf_write_lanes.sv
module bsf_write_lanes #(
    parameter int LANES = 4
)(
    input  logic             live,
    input  logic             byte_wr_en,
    input  logic [LANES-1:0] byte_sel,
    input  logic             global_wr,
    output logic [LANES-1:0] lane_wr
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = live & (global_wr | (byte_wr_en & byte_sel[g]));
    end
endmodule

// File: rtl/burst_addr_front.sv
module burst_addr_front
    import bsf_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 36,
    localparam int LANES = DATA_W / LANE_BITS,
    localparam int UP_W  = ADDR_W - BEAT_BITS
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              chip_en_i,
    input  logic              start_a_i,
    input  logic              start_b_i,
    input  logic              adv_i,
    input  logic              interleave_i,
    input  logic              byte_wr_en_i,
    input  logic [LANES-1:0]  byte_sel_i,
    input  logic              global_wr_i,
    output logic              beat_valid_o,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic [LANES-1:0]  lane_wr_o,
    output logic              desel_o
);
    cmd_e            cmd;
    burst_state_t    st_next;
    logic [UP_W-1:0] upper_next;
    logic [LANES-1:0] lane_next;

    bsf_cmd_decode u_dec (
        .chip_en (chip_en_i),
        .start_a (start_a_i),
        .start_b (start_b_i),
        .adv     (adv_i),
        .cmd     (cmd)
    );

    bsf_burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .addr       (addr_i),
        .st_next    (st_next),
        .upper_next (upper_next)
    );

    bsf_write_lanes #(.LANES(LANES)) u_wr (
        .live       (st_next.live),
        .byte_wr_en (byte_wr_en_i),
        .byte_sel   (byte_sel_i),
        .global_wr  (global_wr_i),
        .lane_wr    (lane_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_valid_o <= 1'b0;
            beat_addr_o  <= '0;
            lane_wr_o    <= '0;
            desel_o      <= 1'b0;
        end else begin
            beat_valid_o <= st_next.live;
            beat_addr_o  <= {upper_next, order_low(st_next.start, st_next.beat, interleave_i)};
            lane_wr_o    <= lane_next;
            desel_o      <= (cmd == CMD_DESEL);
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (beat_valid_o && beat_addr_o == $past(addr_i)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD && beat_valid_o && $stable(interleave_i)) |=> $stable(beat_addr_o));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_HOLD || cmd == CMD_ADV) && beat_valid_o) |=> $stable(beat_addr_o[ADDR_W-1:BEAT_BITS]));

    assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        desel_o |-> (!beat_valid_o && lane_wr_o == '0));

    assert_global_all_R11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && $past(global_wr_i)) |-> (&lane_wr_o));

    assert_idle_nowrite_R12: assert property (@(posedge clk) disable iff (rst)
        !beat_valid_o |-> (lane_wr_o == '0));

endmodule

// File: tb/burst_addr_front_test.sv
`timescale 1ns/1ps
module burst_addr_front_test;
    localparam int AW = 22;
    localparam int LN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic chip_en_i = 0, start_a_i = 0, start_b_i = 0, adv_i = 0, interleave_i = 0;
    logic byte_wr_en_i = 0, global_wr_i = 0;
    logic [LN-1:0] byte_sel_i = '0;
    logic beat_valid_o, desel_o;
    logic [AW-1:0] beat_addr_o;
    logic [LN-1:0] lane_wr_o;

    int checks = 0;
    int errors = 0;

    logic          m_live = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;

    always #4 clk = ~clk;

    burst_addr_front uut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .chip_en_i(chip_en_i),
        .start_a_i(start_a_i), .start_b_i(start_b_i), .adv_i(adv_i),
        .interleave_i(interleave_i), .byte_wr_en_i(byte_wr_en_i),
        .byte_sel_i(byte_sel_i), .global_wr_i(global_wr_i),
        .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o),
        .lane_wr_o(lane_wr_o), .desel_o(desel_o)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base,
                                               input logic [1:0] beat,
                                               input logic ilv);
        logic [1:0] lo;
        lo = ilv ? (base[1:0] ^ beat) : 2'((base[1:0] + beat) % 4);
        return {base[AW-1:2], lo};
    endfunction

    task automatic cycle(input logic ce, input logic sa, input logic sb,
                         input logic ad, input logic ilv, input logic [AW-1:0] a,
                         input logic bwe, input logic [LN-1:0] sel, input logic gw,
                         input string tag);
        logic          e_des;
        logic          e_val;
        logic [AW-1:0] e_addr;
        logic [LN-1:0] e_wr;
        logic [AW+LN+1:0] act, exp;
        chip_en_i = ce; start_a_i = sa; start_b_i = sb; adv_i = ad;
        interleave_i = ilv; addr_i = a; byte_wr_en_i = bwe;
        byte_sel_i = sel; global_wr_i = gw;
        e_des = 1'b0;
        if (sb && !ce) begin
            m_live = 1'b0; e_des = 1'b1;
        end else if (sb || (sa && ce)) begin
            m_live = 1'b1; m_base = a; m_beat = 2'd0;
        end else if (ad && m_live) begin
            m_beat = m_beat + 2'd1;
        end
        e_val  = m_live;
        e_addr = e_val ? exp_addr(m_base, m_beat, ilv) : beat_addr_o;
        e_wr   = !e_val ? '0 : gw ? '1 : bwe ? sel : '0;
        @(negedge clk);
        act = {beat_valid_o, desel_o, (e_val ? beat_addr_o : e_addr), lane_wr_o};
        exp = {e_val, e_des, e_addr, e_wr};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got val=%0b des=%0b addr=%h wr=%b, expected val=%0b des=%0b addr=%h wr=%b",
                     tag, beat_valid_o, desel_o, beat_addr_o, lane_wr_o,
                     e_val, e_des, e_addr, e_wr);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (beat_valid_o !== 1'b0 || lane_wr_o !== '0 || desel_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got val=%0b wr=%b des=%0b expected 0 0 0",
                     beat_valid_o, lane_wr_o, desel_o);
        end
        rst = 1'b0;
        cycle(0, 0, 0, 0, 0, 22'h0, 0, '0, 1, "R1 R12 idle after reset");

        // R7 linear from low=3, with wrap 3,0,1,2
        cycle(1, 1, 1, 0, 0, 22'h2AAAA7, 0, '0, 0, "R2 load both strobes");
        cycle(1, 0, 0, 1, 0, 22'h0, 0, '0, 0, "R7 beat1");
        cycle(1, 0, 0, 1, 0, 22'h0, 0, '0, 0, "R7 beat2");
        cycle(1, 0, 0, 1, 0, 22'h0, 0, '0, 0, "R7 beat3");
        cycle(1, 0, 0, 1, 0, 22'h0, 0, '0, 0, "R7 wrap to start");
        cycle(1, 0, 0, 0, 0, 22'h0, 0, '0, 0, "R6 hold without advance");
        // R8 interleaved from low=2: 2,3,0,1
        cycle(1, 1, 0, 0, 1, 22'h155556, 0, '0, 0, "R3 load strobe a");
        cycle(1, 0, 0, 1, 1, 22'h0, 0, '0, 0, "R8 beat1");
        cycle(0, 1, 0, 1, 1, 22'h3FFFFC, 0, '0, 0, "R4 gated strobe ignored");
        cycle(1, 0, 0, 1, 1, 22'h0, 0, '0, 0, "R8 beat3");
        // R9 back-to-back loads
        cycle(1, 0, 1, 0, 0, 22'h000001, 0, '0, 0, "R9 load 1");
        cycle(1, 1, 0, 0, 0, 22'h000102, 0, '0, 0, "R9 load 2");
        cycle(1, 0, 1, 1, 1, 22'h3F0003, 0, '0, 0, "R9 load 3");
        // writes
        cycle(1, 0, 0, 0, 0, 22'h0, 1, 4'b0101, 0, "R10 byte lanes 0 and 2");
        cycle(1, 0, 0, 0, 0, 22'h0, 1, 4'b1000, 0, "R10 byte lane 3");
        cycle(1, 0, 0, 0, 0, 22'h0, 0, 4'b0000, 1, "R11 global over disabled bytes");
        cycle(1, 0, 0, 0, 0, 22'h0, 1, 4'b0010, 1, "R11 global over one lane");
        cycle(1, 0, 0, 0, 0, 22'h0, 0, 4'b1111, 0, "R12 selects without enable");
        cycle(0, 0, 1, 0, 0, 22'h0, 1, 4'b1111, 1, "R5 deselect");
        cycle(0, 0, 0, 1, 0, 22'h0, 1, 4'b1111, 1, "R12 no write when idle");

        for (int i = 0; i < 4000; i++) begin
            logic ce, sa, sb, ad, ilv, bwe, gw;
            logic [LN-1:0] sel;
            logic [AW-1:0] a;
            string tag;
            ce  = ($urandom % 8) != 0;
            sa  = ($urandom % 4) == 0;
            sb  = ($urandom % 4) == 0;
            ad  = $urandom % 2;
            ilv = ($urandom % 16) < 8;
            bwe = $urandom % 2;
            gw  = ($urandom % 4) == 0;
            sel = LN'($urandom);
            a   = AW'($urandom);
            if (sb && !ce)      tag = "R5 random deselect";
            else if (sb)        tag = "R2 random strobe b";
            else if (sa && ce)  tag = "R3 random strobe a";
            else if (sa)        tag = "R4 random gated strobe";
            else if (ilv)       tag = "R8 random interleaved";
            else                tag = "R7 random linear";
            cycle(ce, sa, sb, ad, ilv, a, bwe, sel, gw, tag);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule